// File: doc/BRIEF.md
# Signed Remainder and Modulus Divider

This block divides a signed dividend by a signed divisor, both of a width set by a parameter. Each operation produces three results. The first is the quotient, truncated toward zero. The second is the remainder, which carries the sign of the dividend. The third is the modulus, which carries the sign of the divisor. The division itself works on operand magnitudes with a restoring shift-and-subtract loop that settles one quotient bit per clock. A small correction stage then rebuilds the signs and derives the modulus from the remainder.

Operands enter through a valid/ready handshake. `in_ready` is high only while the divider is idle. An operand pair is taken on a rising edge where `in_valid` and `in_ready` are both high. While a division is running, `in_ready` stays low, and any `in_valid` in that time is dropped. A source that wants its operands taken must hold them until it sees `in_ready`. The result side has no back-pressure. `out_valid` pulses for one cycle, and the result outputs keep their value until the next result. A divisor of zero raises `out_div_zero` alongside `out_valid`, and all three results are zero in that case.

Top module: `sdiv_remmod`

## Requirements
- R1: `out_quotient` equals the dividend divided by the divisor, truncated toward zero and wrapped to W bits, so that quotient*divisor + remainder equals the dividend modulo 2^W.
- R2: `out_remainder` is zero or has the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R3: `out_modulus` is zero or has the sign of the divisor. It equals the remainder plus the divisor when the remainder is nonzero and the operand signs differ, and it equals the remainder otherwise.
- R4: For these fixed cases: 11 rem 4 is 3, -11 rem 4 is -3, 9 mod 4 is 1, and 7 mod -4 is -1.
- R5: `out_valid` is high for exactly one cycle, W+1 rising edges after the edge that accepts the operands. `in_ready` is high again in that same cycle.
- R6: `in_ready` is low from the edge after acceptance until the result cycle. An `in_valid` during that time changes no result and produces no extra `out_valid`.
- R7: A zero divisor sets `out_div_zero` in the result cycle and makes quotient, remainder and modulus zero. A nonzero divisor leaves the flag low.
- R8: The most negative value divided by -1 gives the most negative value as quotient, zero remainder, zero modulus, and `out_div_zero` low.
- R9: After reset, `in_ready` is 1, `out_valid` is 0, and all result outputs and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Divider idle and able to take operands |
| in_dividend | input | W | Signed dividend |
| in_divisor | input | W | Signed divisor |
| out_valid | output | 1 | One-cycle result strobe |
| out_quotient | output | W | Signed quotient, truncated toward zero |
| out_remainder | output | W | Remainder with the sign of the dividend |
| out_modulus | output | W | Modulus with the sign of the divisor |
| out_div_zero | output | 1 | Divisor was zero |

## Verification
The checker samples the operands only on an accepting edge. It assumes that each result belongs to the most recently accepted pair, which holds only if no second pair can be taken while a division is running. The bench therefore drives `in_valid` freely during busy periods, to test that those offers are dropped, and it starts a new operation only after it has seen `in_ready` high. The arithmetic relations in the checker are written in W-bit wrapping arithmetic. Because of that, the overflow case of the most negative value divided by -1 stays inside what the checker accepts, and the bench includes that case on purpose.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    SD_IDLE = 2'd0,
    SD_RUN  = 2'd1,
    SD_FIX  = 2'd2
  } sdiv_state_e;

endpackage

// File: rtl/sdiv_sign_split.sv
module sdiv_sign_split #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic [W-1:0] mag,
  output logic         neg
);
  // The magnitude is unsigned, so the most negative value maps to 2^(W-1).
  always_comb begin
    neg = value[W-1];
    mag = neg ? (~value + 1'b1) : value;
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  localparam int PW = W + 1;

  logic [PW-1:0] part_q;
  logic [W-1:0]  acc_q;
  logic [W-1:0]  dvs_q;
  logic [PW-1:0] shifted;
  logic [PW-1:0] trial;
  logic          fits;

  always_comb begin
    shifted = {part_q[W-1:0], acc_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = ~trial[PW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      acc_q  <= '0;
      dvs_q  <= '0;
    end else if (load) begin
      part_q <= '0;
      acc_q  <= dvd_mag;
      dvs_q  <= dvs_mag;
    end else if (step) begin
      part_q <= fits ? trial : shifted;
      acc_q  <= {acc_q[W-2:0], fits};
    end
  end

  assign quo_mag = acc_q;
  assign rem_mag = part_q[W-1:0];
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
  parameter int W = 8
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         dvd_neg,
  input  logic         dvs_neg,
  input  logic [W-1:0] divisor,
  input  logic         div_zero,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic [W-1:0] modv
);
  logic [W-1:0] q_signed;
  logic [W-1:0] r_signed;
  logic         signs_differ;

  always_comb begin
    signs_differ = dvd_neg ^ dvs_neg;
    q_signed     = signs_differ ? (~quo_mag + 1'b1) : quo_mag;
    r_signed     = dvd_neg ? (~rem_mag + 1'b1) : rem_mag;
    if (div_zero) begin
      quo  = '0;
      rem  = '0;
      modv = '0;
    end else begin
      quo  = q_signed;
      rem  = r_signed;
      modv = ((r_signed != '0) && signs_differ) ? (r_signed + divisor) : r_signed;
    end
  end
endmodule

// File: rtl/sdiv_remmod.sv
module sdiv_remmod
  import sdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder,
  output logic [W-1:0] out_modulus,
  output logic         out_div_zero
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  sdiv_state_e state_q;
  logic [CW-1:0] step_cnt_q;
  logic          dvd_neg_q, dvs_neg_q, zero_q;
  logic [W-1:0]  divisor_q;

  logic [W-1:0]  dvd_mag, dvs_mag;
  logic          dvd_neg, dvs_neg;
  logic [W-1:0]  quo_mag, rem_mag;
  logic [W-1:0]  fx_quo, fx_rem, fx_mod;
  logic          accept, stepping;

  assign in_ready = (state_q == SD_IDLE);
  assign accept   = in_valid && in_ready;
  assign stepping = (state_q == SD_RUN);

  sdiv_sign_split #(.W(W)) u_split_dvd (
    .value(in_dividend), .mag(dvd_mag), .neg(dvd_neg)
  );

  sdiv_sign_split #(.W(W)) u_split_dvs (
    .value(in_divisor), .mag(dvs_mag), .neg(dvs_neg)
  );

  sdiv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(stepping),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .quo_mag(quo_mag), .rem_mag(rem_mag)
  );

  sdiv_fixup #(.W(W)) u_fixup (
    .quo_mag(quo_mag), .rem_mag(rem_mag),
    .dvd_neg(dvd_neg_q), .dvs_neg(dvs_neg_q),
    .divisor(divisor_q), .div_zero(zero_q),
    .quo(fx_quo), .rem(fx_rem), .modv(fx_mod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SD_IDLE;
      step_cnt_q <= '0;
      dvd_neg_q  <= 1'b0;
      dvs_neg_q  <= 1'b0;
      zero_q     <= 1'b0;
      divisor_q  <= '0;
    end else begin
      case (state_q)
        SD_IDLE: if (accept) begin
          state_q    <= SD_RUN;
          step_cnt_q <= '0;
          dvd_neg_q  <= dvd_neg;
          dvs_neg_q  <= dvs_neg;
          zero_q     <= (in_divisor == '0);
          divisor_q  <= in_divisor;
        end
        SD_RUN: begin
          step_cnt_q <= step_cnt_q + 1'b1;
          if (step_cnt_q == LAST_STEP) state_q <= SD_FIX;
        end
        default: state_q <= SD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_quotient  <= '0;
      out_remainder <= '0;
      out_modulus   <= '0;
      out_div_zero  <= 1'b0;
    end else begin
      out_valid <= (state_q == SD_FIX);
      if (state_q == SD_FIX) begin
        out_quotient  <= fx_quo;
        out_remainder <= fx_rem;
        out_modulus   <= fx_mod;
        out_div_zero  <= zero_q;
      end
    end
  end
endmodule

// File: rtl/sdiv_remmod_checker.sv
module sdiv_remmod_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_dividend,
  input logic [W-1:0] in_divisor,
  input logic         out_valid,
  input logic [W-1:0] out_quotient,
  input logic [W-1:0] out_remainder,
  input logic [W-1:0] out_modulus,
  input logic         out_div_zero
);
  logic [W-1:0] cap_a, cap_b;
  logic         pend;
  int unsigned  lat;
  logic [W-1:0] recon;
  logic [W-1:0] rem_plus_b;

  always_comb begin
    recon      = out_quotient * cap_b + out_remainder;
    rem_plus_b = out_remainder + cap_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      pend  <= 1'b0;
      lat   <= 0;
    end else if (in_valid && in_ready) begin
      cap_a <= in_dividend;
      cap_b <= in_divisor;
      pend  <= 1'b1;
      lat   <= 0;
    end else begin
      if (out_valid) pend <= 1'b0;
      if (pend) lat <= lat + 1;
    end
  end

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend && lat == W + 1));
  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_div_zero) |-> (recon == cap_a));
  a_r2_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_remainder != '0) |-> (out_remainder[W-1] == cap_a[W-1]));
  a_r3_mod_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_modulus != '0) |-> (out_modulus[W-1] == cap_b[W-1]));
  a_r3_mod_rel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_div_zero) |-> (out_modulus == out_remainder || out_modulus == rem_plus_b));
  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_div_zero == (cap_b == '0)));
  a_r7_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_div_zero) |-> (out_quotient == '0 && out_remainder == '0 && out_modulus == '0));
endmodule

bind sdiv_remmod sdiv_remmod_checker #(.W(W)) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dividend(in_dividend), .in_divisor(in_divisor), .out_valid(out_valid),
  .out_quotient(out_quotient), .out_remainder(out_remainder),
  .out_modulus(out_modulus), .out_div_zero(out_div_zero)
);

// File: tb/sdiv_remmod_test.sv
module sdiv_remmod_test;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic         out_valid;
  logic [W-1:0] out_quotient, out_remainder, out_modulus;
  logic         out_div_zero;

  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  bit     finished = 0;

  typedef struct {
    int     q;
    int     r;
    int     m;
    bit     dz;
    longint due;
    string  req;
  } exp_t;

  exp_t sb[$];
  exp_t got;

  sdiv_remmod #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .out_valid(out_valid),
    .out_quotient(out_quotient), .out_remainder(out_remainder),
    .out_modulus(out_modulus), .out_div_zero(out_div_zero)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wrapw(int v);
    logic signed [W-1:0] t;
    t = v[W-1:0];
    return int'(t);
  endfunction

  function automatic int sv(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Driver: computes the expected item from the requirements and offers the operands.
  task automatic drive(int a, int b, string req);
    exp_t e;
    int fq;
    e.req = req;
    if (b == 0) begin
      e.q = 0; e.r = 0; e.m = 0; e.dz = 1;
    end else begin
      e.q  = wrapw(a / b);
      e.r  = a % b;
      fq   = a / b;
      if (e.r != 0 && ((a < 0) != (b < 0))) fq = fq - 1;
      e.m  = wrapw(a - b * fq);
      e.dz = 0;
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = a[W-1:0];
    in_divisor  = b[W-1:0];
    e.due = cyc + 1 + W + 1;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every result strobe.
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (sb.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6 unexpected result: actual out_valid 1 expected 0");
      end else begin
        got = sb.pop_front();
        chk({got.req, " R1"}, "quotient", sv(out_quotient), got.q);
        chk({got.req, " R2"}, "remainder", sv(out_remainder), got.r);
        chk({got.req, " R3"}, "modulus", sv(out_modulus), got.m);
        chk({got.req, " R7"}, "div_zero", int'(out_div_zero), int'(got.dz));
        chk("R5", "result cycle", int'(cyc), int'(got.due));
        chk("R5", "in_ready in result cycle", int'(in_ready), 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int av[12] = '{-128, -127, -11, -7, -1, 0, 1, 7, 9, 11, 100, 127};
    int bv[9]  = '{-128, -4, -3, -1, 1, 3, 4, 127, 0};
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "in_ready", int'(in_ready), 1);
    chk("R9", "out_valid", int'(out_valid), 0);
    chk("R9", "quotient", sv(out_quotient), 0);
    chk("R9", "remainder", sv(out_remainder), 0);
    chk("R9", "modulus", sv(out_modulus), 0);
    chk("R9", "div_zero", int'(out_div_zero), 0);
    rst_n = 1'b1;

    // R4 fixed cases
    drive(11, 4, "R4");
    drive(-11, 4, "R4");
    drive(9, 4, "R4");
    drive(7, -4, "R4");
    // R8 overflow case
    drive(-128, -1, "R8");
    // R7 zero divisor
    drive(-77, 0, "R7");

    // R6 offers while busy are dropped
    drive(100, 7, "R6");
    for (int i = 0; i < 3; i++) begin
      chk("R6", "in_ready while busy", int'(in_ready), 0);
      in_valid    = 1'b1;
      in_dividend = 8'hFB;
      in_divisor  = 8'h03;
      @(negedge clk);
    end
    in_valid = 1'b0;

    // Sign and magnitude sweep
    foreach (av[i]) foreach (bv[j]) drive(av[i], bv[j], "R1");

    for (int k = 0; k < 40 && sb.size() != 0; k++) @(negedge clk);
    repeat (W + 4) @(negedge clk);
    chk("R6", "pending results", sb.size(), 0);
    finish_run();
  end
endmodule